// File: doc/BRIEF.md
# SPI Flash Read Emulator

This block stands on a SPI NOR flash bus in place of the flash part and answers the plain read command (0x03) from a 16-bit-wide DRAM-style memory whose random reads take several memory clocks. The SPI chip select, clock and data-in lines are brought into the fast system clock through two-flop synchronisers. All bus edges are found there, so the whole block runs on one clock.

A DRAM read needs a row activate, a row-to-column wait and then a column read with its own latency. These cannot all fit in the half SPI bit that follows the last address bit. The block therefore starts the memory access while the address is still arriving. The 14 most significant address bits go out as a row activate as soon as they are in. The next 9 bits go out as a column read one bit before the address ends. The final address bit only picks a byte out of the 16-bit word that comes back.

Reading continues byte after byte for as long as the host keeps clocking. The next word is fetched while the byte before it is still being shifted out. A new row is opened first when the column count wraps.

Top module: `flash_read_emu`

## Requirements
- R1: After reset, and while chip select is high, the serial-out enable is 0, busy is 0 and neither memory request is raised.
- R2: The first 8 bits after chip select falls form the command, taken MSB first on rising SPI clock edges. Any value other than 0x03 keeps the serial-out enable at 0 and raises no memory request until chip select rises.
- R3: On the rising edge carrying the 14th address bit, a one-cycle row request is raised with the row output equal to address bits [23:10].
- R4: On the rising edge carrying the 23rd address bit, a one-cycle column request is raised with the column output equal to address bits [9:1]. Within a transaction a column request never comes before a row request.
- R5: Address bit 0 selects the byte of the returned word: 0 selects bits [7:0] and 1 selects bits [15:8].
- R6: The first data bit appears on serial-out after the falling SPI edge that follows the last address bit. Bytes go out MSB first, and serial-out changes only after a detected falling edge.
- R7: After each byte the byte address advances by one. Each time a byte with address bit 0 equal to 1 is loaded, a column request for the following word is raised at the next rising SPI edge.
- R8: When that following word lies in the next row (column bits all ones), a row request for row+1 (modulo the row range) is raised when the byte is loaded, and this comes before the column request. A row request and a column request never share a cycle.
- R9: Serial-out is enabled only while read data is being shifted. It is off by the fourth system clock after chip select has gone high.
- R10: Busy rises with the row request and stays high until chip select rises. The serial-out enable is never high without busy.
- R11: Raising chip select at any point ends the transaction, and the next transaction decodes a fresh command and address.
- R12: A memory word is taken on the cycle its valid strobe is high, and it may be used in that same cycle. With a system clock at least 8 times the SPI clock, a return latency of 7 cycles delivers correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_sclk_i | input | 1 | SPI clock from the host |
| spi_mosi_i | input | 1 | SPI serial data from the host |
| spi_miso_o | output | 1 | SPI serial data to the host |
| spi_miso_oe_o | output | 1 | Output enable for spi_miso_o (0 = high impedance) |
| busy_o | output | 1 | A read transaction holds the memory |
| mem_row_req_o | output | 1 | One-cycle row activate request |
| mem_row_o | output | ROW_W | Row and bank address |
| mem_col_req_o | output | 1 | One-cycle column read request |
| mem_col_o | output | ADDR_W-ROW_W-1 | Column (word) address |
| mem_rdata_i | input | WORD_W | Word returned by memory |
| mem_rvalid_i | input | 1 | mem_rdata_i is valid this cycle |

## Verification
The bench goes after the column wrap inside a burst, including the wrap of the whole address space. A design that skipped the row request there would return bytes from the old row. It starts bursts on odd addresses, where a swapped byte select shows up on the very first byte and an early or late prefetch corrupts the second. It sends unsupported commands and aborts transactions both before and after the row request: a block that kept driving serial-out, or left busy set, or carried a stale bit count into the next transaction, would fail the checks. Memory latency is held at the 7-cycle maximum, so an output stage that loads its byte before the word has been latched sends wrong data.

// File: rtl/flash_emu_pkg.sv
`timescale 1ns/1ps
package flash_emu_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] CMD_NORMAL_READ = 8'h03;
    localparam int CMD_BITS = 8;

endpackage

// File: rtl/fe_sync_edge.sv
`timescale 1ns/1ps
module fe_sync_edge #(
    parameter int          W        = 3,
    parameter int          EDGE_IDX = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic         rise_o,
    output logic         fall_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic         prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = async_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2[EDGE_IDX];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q.s1   <= RST_VAL;
            sync_q.s2   <= RST_VAL;
            sync_q.prev <= RST_VAL[EDGE_IDX];
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.s2;
    assign rise_o  = sync_q.s2[EDGE_IDX] & ~sync_q.prev;
    assign fall_o  = ~sync_q.s2[EDGE_IDX] & sync_q.prev;

endmodule

// File: rtl/fe_cmd_decoder.sv
`timescale 1ns/1ps
module fe_cmd_decoder
    import flash_emu_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int ROW_W  = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cs_act_i,
    input  logic             sclk_rise_i,
    input  logic             mosi_i,
    output logic             data_phase_o,
    output logic             row_ev_o,
    output logic             col_ev_o,
    output logic             sel_ev_o,
    output logic [ROW_W-1:0] field_o
);

    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] ROW_LAST = CNT_W'(ROW_W - 1);
    localparam logic [CNT_W-1:0] COL_LAST = CNT_W'(ADDR_W - 2);
    localparam logic [CNT_W-1:0] SEL_LAST = CNT_W'(ADDR_W - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-2:0] sh;
    } dec_t;

    dec_t dec_d, dec_q;
    logic [ROW_W-1:0] shifted;

    assign shifted = {dec_q.sh, mosi_i};

    always_comb begin
        dec_d    = dec_q;
        row_ev_o = 1'b0;
        col_ev_o = 1'b0;
        sel_ev_o = 1'b0;
        if (!cs_act_i) begin
            dec_d.ph  = PH_IDLE;
            dec_d.cnt = '0;
        end else begin
            unique case (dec_q.ph)
                PH_IDLE, PH_CMD: begin
                    dec_d.ph = PH_CMD;
                    if (sclk_rise_i) begin
                        dec_d.sh  = shifted[ROW_W-2:0];
                        dec_d.cnt = dec_q.cnt + CNT_W'(1);
                        if (dec_q.cnt == CMD_LAST) begin
                            dec_d.cnt = '0;
                            dec_d.ph  = (shifted[CMD_BITS-1:0] == CMD_NORMAL_READ)
                                        ? PH_ADDR : PH_SKIP;
                        end
                    end
                end
                PH_ADDR: begin
                    if (sclk_rise_i) begin
                        dec_d.sh  = shifted[ROW_W-2:0];
                        dec_d.cnt = dec_q.cnt + CNT_W'(1);
                        if (dec_q.cnt == ROW_LAST) row_ev_o = 1'b1;
                        if (dec_q.cnt == COL_LAST) col_ev_o = 1'b1;
                        if (dec_q.cnt == SEL_LAST) begin
                            sel_ev_o = 1'b1;
                            dec_d.ph = PH_DATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign field_o      = shifted;
    assign data_phase_o = (dec_q.ph == PH_DATA) && cs_act_i;

    AST_SKIP_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_q.ph == PH_SKIP) |=> (dec_q.ph != PH_DATA)); // R2

endmodule

// File: rtl/fe_word_fetch.sv
`timescale 1ns/1ps
module fe_word_fetch #(
    parameter int ADDR_W = 24,
    parameter int ROW_W  = 14,
    parameter int WORD_W = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      cs_act_i,
    input  logic                      sclk_rise_i,
    input  logic                      row_ev_i,
    input  logic                      col_ev_i,
    input  logic                      sel_ev_i,
    input  logic [ROW_W-1:0]          field_i,
    input  logic                      take_i,
    input  logic [WORD_W-1:0]         mem_rdata_i,
    input  logic                      mem_rvalid_i,
    output logic [WORD_W/2-1:0]       byte_o,
    output logic                      row_req_o,
    output logic [ROW_W-1:0]          row_o,
    output logic                      col_req_o,
    output logic [ADDR_W-ROW_W-2:0]   col_o,
    output logic                      busy_o
);

    localparam int COL_W  = ADDR_W - ROW_W - 1;
    localparam int BYTE_W = WORD_W / 2;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              sel;
        logic [WORD_W-1:0] word;
        logic              row_req;
        logic              col_req;
        logic              pend;
        logic              busy;
        logic              row_open;
    } fetch_t;

    fetch_t f_d, f_q;
    logic [WORD_W-1:0] cur_word;

    always_comb begin
        f_d         = f_q;
        f_d.row_req = 1'b0;
        f_d.col_req = 1'b0;
        if (mem_rvalid_i) f_d.word = mem_rdata_i;
        if (!cs_act_i) begin
            f_d.busy     = 1'b0;
            f_d.pend     = 1'b0;
            f_d.row_open = 1'b0;
        end else begin
            if (row_ev_i) begin
                f_d.row      = field_i;
                f_d.row_req  = 1'b1;
                f_d.busy     = 1'b1;
                f_d.row_open = 1'b1;
            end
            if (col_ev_i) begin
                f_d.col     = field_i[COL_W-1:0];
                f_d.col_req = 1'b1;
            end
            if (sel_ev_i) f_d.sel = field_i[0];
            if (take_i) begin
                if (f_q.sel) begin
                    f_d.sel  = 1'b0;
                    f_d.col  = f_q.col + COL_W'(1);
                    f_d.pend = 1'b1;
                    if (&f_q.col) begin
                        f_d.row     = f_q.row + ROW_W'(1);
                        f_d.row_req = 1'b1;
                    end
                end else begin
                    f_d.sel = 1'b1;
                end
            end
            if (f_q.pend && sclk_rise_i) begin
                f_d.col_req = 1'b1;
                f_d.pend    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign cur_word  = mem_rvalid_i ? mem_rdata_i : f_q.word;
    assign byte_o    = f_q.sel ? cur_word[WORD_W-1:BYTE_W] : cur_word[BYTE_W-1:0];
    assign row_req_o = f_q.row_req;
    assign row_o     = f_q.row;
    assign col_req_o = f_q.col_req;
    assign col_o     = f_q.col;
    assign busy_o    = f_q.busy;

    AST_ROW_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        row_req_o |=> !row_req_o); // R3
    AST_COL_AFTER_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        col_req_o |-> f_q.row_open); // R4
    AST_REQ_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(row_req_o && col_req_o)); // R8
    AST_COL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        col_req_o |=> !col_req_o); // R4

endmodule

// File: rtl/fe_tx_shift.sv
`timescale 1ns/1ps
module fe_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              active_i,
    input  logic              fall_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              take_o,
    output logic              miso_o,
    output logic              oe_o
);

    localparam int CW = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CW-1:0]     cnt;
        logic              miso;
        logic              oe;
    } tx_t;

    tx_t tx_d, tx_q;

    assign take_o = active_i && fall_i && (tx_q.cnt == '0);

    always_comb begin
        tx_d = tx_q;
        if (!active_i) begin
            tx_d.oe   = 1'b0;
            tx_d.cnt  = '0;
            tx_d.miso = 1'b0;
        end else if (take_o) begin
            tx_d.sh   = {byte_i[BYTE_W-2:0], 1'b0};
            tx_d.miso = byte_i[BYTE_W-1];
            tx_d.cnt  = CW'(BYTE_W - 1);
            tx_d.oe   = 1'b1;
        end else if (fall_i) begin
            tx_d.miso = tx_q.sh[BYTE_W-1];
            tx_d.sh   = {tx_q.sh[BYTE_W-2:0], 1'b0};
            tx_d.cnt  = tx_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign miso_o = tx_q.miso;
    assign oe_o   = tx_q.oe;

    AST_MISO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (oe_o && $past(oe_o) && (miso_o != $past(miso_o))) |-> $past(fall_i)); // R6

endmodule

// File: rtl/flash_read_emu.sv
`timescale 1ns/1ps
module flash_read_emu #(
    parameter int ADDR_W = 24,
    parameter int ROW_W  = 14,
    parameter int WORD_W = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    spi_cs_ni,
    input  logic                    spi_sclk_i,
    input  logic                    spi_mosi_i,
    output logic                    spi_miso_o,
    output logic                    spi_miso_oe_o,
    output logic                    busy_o,
    output logic                    mem_row_req_o,
    output logic [ROW_W-1:0]        mem_row_o,
    output logic                    mem_col_req_o,
    output logic [ADDR_W-ROW_W-2:0] mem_col_o,
    input  logic [WORD_W-1:0]       mem_rdata_i,
    input  logic                    mem_rvalid_i
);

    localparam int BYTE_W = WORD_W / 2;
    localparam int IDX_CS = 0;
    localparam int IDX_CK = 1;
    localparam int IDX_DI = 2;

    logic [2:0]        lvl;
    logic              sclk_rise, sclk_fall, cs_act;
    logic              data_phase, row_ev, col_ev, sel_ev, take;
    logic [ROW_W-1:0]  field;
    logic [BYTE_W-1:0] tx_byte;

    fe_sync_edge #(
        .W       (3),
        .EDGE_IDX(IDX_CK),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i({spi_mosi_i, spi_sclk_i, spi_cs_ni}),
        .level_o(lvl),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );

    assign cs_act = ~lvl[IDX_CS];

    fe_cmd_decoder #(
        .ADDR_W(ADDR_W),
        .ROW_W (ROW_W)
    ) u_dec (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cs_act_i    (cs_act),
        .sclk_rise_i (sclk_rise),
        .mosi_i      (lvl[IDX_DI]),
        .data_phase_o(data_phase),
        .row_ev_o    (row_ev),
        .col_ev_o    (col_ev),
        .sel_ev_o    (sel_ev),
        .field_o     (field)
    );

    fe_word_fetch #(
        .ADDR_W(ADDR_W),
        .ROW_W (ROW_W),
        .WORD_W(WORD_W)
    ) u_fetch (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cs_act_i    (cs_act),
        .sclk_rise_i (sclk_rise),
        .row_ev_i    (row_ev),
        .col_ev_i    (col_ev),
        .sel_ev_i    (sel_ev),
        .field_i     (field),
        .take_i      (take),
        .mem_rdata_i (mem_rdata_i),
        .mem_rvalid_i(mem_rvalid_i),
        .byte_o      (tx_byte),
        .row_req_o   (mem_row_req_o),
        .row_o       (mem_row_o),
        .col_req_o   (mem_col_req_o),
        .col_o       (mem_col_o),
        .busy_o      (busy_o)
    );

    fe_tx_shift #(
        .BYTE_W(BYTE_W)
    ) u_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .active_i(data_phase),
        .fall_i  (sclk_fall),
        .byte_i  (tx_byte),
        .take_o  (take),
        .miso_o  (spi_miso_o),
        .oe_o    (spi_miso_oe_o)
    );

    AST_OE_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spi_miso_oe_o |-> busy_o); // R10
    AST_CS_HIGH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (spi_cs_ni && $past(spi_cs_ni) && $past(spi_cs_ni, 2) && $past(spi_cs_ni, 3))
        |-> (!spi_miso_oe_o && !busy_o && !mem_row_req_o && !mem_col_req_o)); // R9

endmodule

// File: tb/flash_read_emu_tb.sv
`timescale 1ns/1ps
module flash_read_emu_tb_top;

    localparam int HALF = 4;
    localparam int LAT  = 7;
    localparam int WD   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        miso, miso_oe, busy;
    logic        row_req, col_req;
    logic [13:0] row;
    logic [8:0]  col;
    logic [15:0] rdata = '0;
    logic        rvalid = 1'b0;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    logic [13:0] exp_row[$];
    logic [8:0]  exp_col[$];
    logic [13:0] open_row = '0;
    logic [15:0] pend_word = '0;
    int          lat_cnt = 0;

    always #10 clk = ~clk;

    flash_read_emu dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .spi_cs_ni    (cs_n),
        .spi_sclk_i   (sclk),
        .spi_mosi_i   (mosi),
        .spi_miso_o   (miso),
        .spi_miso_oe_o(miso_oe),
        .busy_o       (busy),
        .mem_row_req_o(row_req),
        .mem_row_o    (row),
        .mem_col_req_o(col_req),
        .mem_col_o    (col),
        .mem_rdata_i  (rdata),
        .mem_rvalid_i (rvalid)
    );

    function automatic logic [15:0] word_of(input logic [22:0] idx);
        longint t;
        t = longint'(idx) * 40503 + 12345;
        return t[15:0] ^ t[31:16];
    endfunction

    function automatic logic [7:0] flash_byte(input logic [23:0] a);
        logic [15:0] w;
        w = word_of(a[23:1]);
        return a[0] ? w[15:8] : w[7:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Memory model and request monitor, compared on every clock
    always @(negedge clk) begin
        rvalid = 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                rvalid = 1'b1;
                rdata  = pend_word;
            end
        end
        if (rst_n && row_req) begin
            if (exp_row.size() == 0) chk(0, "R2", "unexpected row request", row, 0);
            else begin
                logic [13:0] e;
                e = exp_row.pop_front();
                chk(row == e, "R3", "row address", row, e);
            end
            open_row = row;
        end
        if (rst_n && col_req) begin
            if (exp_col.size() == 0) chk(0, "R2", "unexpected column request", col, 0);
            else begin
                logic [8:0] e;
                e = exp_col.pop_front();
                chk(col == e, "R4", "column address", col, e);
            end
            pend_word = word_of({open_row, col});
            lat_cnt   = LAT;
        end
    end

    task automatic spi_xfer(input logic [7:0] cmd, input logic [23:0] addr,
                            input int nbytes, input int stop_bits, input string tag);
        int          total;
        bit          is_read;
        bit          oe_seen;
        logic [7:0]  rx;
        is_read = (cmd == 8'h03);
        total   = (stop_bits > 0) ? stop_bits : 32 + 8 * nbytes;
        oe_seen = 0;
        rx      = '0;
        if (is_read) begin
            if (total >= 22) exp_row.push_back(addr[23:10]);
            if (total >= 31) exp_col.push_back(addr[9:1]);
            if (total >= 32) begin
                for (int k = 0; k < nbytes; k++) begin
                    logic [23:0] a, na;
                    a  = addr + 24'(k);
                    na = a + 24'd1;
                    if (a[0]) begin
                        if (na[9:1] == 9'd0) exp_row.push_back(na[23:10]);
                        exp_col.push_back(na[9:1]);
                    end
                end
            end
        end
        cs_n = 1'b0;
        wait_n(HALF);
        for (int i = 0; i < total; i++) begin
            mosi = (i < 8) ? cmd[7-i] : ((i < 32) ? addr[31-i] : 1'b0);
            wait_n(HALF);
            if (!is_read && i >= 8 && miso_oe) oe_seen = 1;
            if (is_read && i >= 32) begin
                int bi;
                bi = i - 32;
                if (bi == 0) begin
                    chk(miso_oe == 1'b1, "R6", "serial-out enable at first data bit", miso_oe, 1);
                    chk(busy == 1'b1, "R10", "busy during data", busy, 1);
                end
                rx = {rx[6:0], miso};
                if (bi % 8 == 7) begin
                    logic [7:0] e;
                    e = flash_byte(addr + 24'(bi / 8));
                    chk(rx == e, tag, $sformatf("data byte %0d", bi / 8), rx, e);
                end
            end
            sclk = 1'b1;
            wait_n(HALF);
            if (i != total - 1) sclk = 1'b0;
        end
        cs_n = 1'b1;
        wait_n(3);
        sclk = 1'b0;
        mosi = 1'b0;
        wait_n(HALF + 4);
        if (!is_read) chk(!oe_seen, "R2", "serial-out enabled for other command", oe_seen, 0);
        chk(miso_oe == 1'b0, "R9", "serial-out enable after chip select high", miso_oe, 0);
        chk(busy == 1'b0, "R10", "busy after chip select high", busy, 0);
        chk(exp_row.size() == 0, "R8", "row requests missing", exp_row.size(), 0);
        chk(exp_col.size() == 0, "R7", "column requests missing", exp_col.size(), 0);
        exp_row.delete();
        exp_col.delete();
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(4);
        chk(miso_oe == 1'b0, "R1", "reset serial-out enable", miso_oe, 0);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(row_req == 1'b0 && col_req == 1'b0, "R1", "reset requests", {row_req, col_req}, 0);

        spi_xfer(8'h03, 24'h123456, 2, 0, "R12");
        spi_xfer(8'h03, 24'h0ABC01, 3, 0, "R5");
        spi_xfer(8'h03, 24'h0ABC00, 1, 0, "R5");
        spi_xfer(8'h0B, 24'h000010, 4, 0, "R2");
        spi_xfer(8'h9F, 24'h000000, 2, 0, "R2");
        spi_xfer(8'h03, 24'h000010, 8, 0, "R7");
        spi_xfer(8'h03, 24'h0557FE, 5, 0, "R8");
        spi_xfer(8'h03, 24'hFFFFFD, 4, 0, "R8");
        spi_xfer(8'h03, 24'h2468AC, 0, 20, "R11");
        spi_xfer(8'h03, 24'h13579B, 0, 24, "R11");
        spi_xfer(8'h03, 24'h3C0002, 2, 0, "R11");
        spi_xfer(8'h03, 24'h7FFFFF, 3, 0, "R6");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule